// File: doc/BRIEF.md
# Layer-4 Header Error Classifier

This block watches the transport-layer portion of a received packet as it streams past one byte per accepted beat. While the bytes flow it captures the fields of a TCP or UDP header that matter for sanity checking: the two port numbers, the UDP length and checksum fields, the TCP data offset and the TCP control flags. It also folds every byte into a running ones'-complement sum that is seeded with a pseudo-header partial sum supplied by the IP stage upstream.

When the last byte of the packet has been taken, the block issues a single verdict: a 4-bit code together with a one-cycle done strobe. The code says whether the header is too short, whether its length disagrees with the length given by the IP layer, whether a port is zero, whether the TCP flag byte holds one of six illegal combinations, or whether the checksum does not verify. A downstream stage uses the code to drop or flag the packet. Protocol number, IP-derived length and the pseudo-header sum are sideband values that are only meaningful on the first byte of each packet.

Top module: `l4_err_classifier`

## Requirements
- R1: A packet with protocol 6 (TCP) or 17 (UDP) and none of the faults below gets code 0; a packet with any other protocol number always gets code 0.
- R2: Code 1 (malformed) is given when the byte count is below 20 for TCP or below 8 for UDP, or for TCP when the data offset (upper nibble of byte 12) is below 5 or four times it exceeds the byte count.
- R3: Code 3 (length mismatch) is given when the byte count differs from the IP-derived length, or for UDP when the length field (bytes 4-5, big-endian) differs from it.
- R4: Code 4 is given when the source port (bytes 0-1) or the destination port (bytes 2-3) is zero.
- R5: For TCP, with the flag byte at offset 13 and its bits 0 FIN, 1 SYN, 2 RST, 5 URG, the code is 8 when bits 5:0 equal 000001, 9 when bits 5:0 are all zero, 10 for FIN and RST, 11 for SYN and URG, 12 for SYN and RST, 13 for SYN and FIN, other bits being free in codes 10 to 13; when several apply, the lowest code wins.
- R6: Code 2 is given when the ones'-complement sum of the pseudo-header seed and all packet bytes taken as big-endian 16-bit words (a trailing odd byte padded with a low zero byte) is not 0xFFFF.
- R7: A UDP packet whose checksum field (bytes 6-7) is zero never gets code 2.
- R8: When several faults apply, the code reported is the first of: malformed, length mismatch, zero port, flag codes, checksum.
- R9: The done strobe is high for exactly the one cycle after the beat carrying end-of-packet is accepted, and the code output is 0 whenever the strobe is low.
- R10: Beats with the valid input low change nothing, and protocol, IP length and seed are taken only from the start-of-packet beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A byte is presented this cycle |
| in_sop | input | 1 | The byte is the first of its packet |
| in_eop | input | 1 | The byte is the last of its packet |
| in_data | input | 8 | Packet byte |
| ip_proto | input | 8 | IP protocol number, sampled with the first byte |
| ip_l4_len | input | LEN_W | Layer-4 length derived from the IP header, sampled with the first byte |
| ip_psum | input | 16 | Pseudo-header ones'-complement partial sum, sampled with the first byte |
| verdict_valid | output | 1 | One-cycle done strobe |
| verdict_code | output | 4 | Error code, valid with the strobe |

## Verification
The assertions assume every packet opens with a start-of-packet beat and that no packet is longer than the byte counter can hold, so that the captured fields and the count belong to a single packet when the verdict appears. The stimulus always marks the first byte with start-of-packet, keeps packets at 64 bytes or fewer, and fills idle beats and non-first beats with random strobes and random sideband values so that anything the block wrongly listened to would disturb the verdict.

// File: rtl/l4cls_pkg.sv
package l4cls_pkg;

  typedef enum logic [3:0] {
    ERR_NONE      = 4'd0,
    ERR_MALFORMED = 4'd1,
    ERR_CSUM      = 4'd2,
    ERR_LENGTH    = 4'd3,
    ERR_PORT0     = 4'd4,
    ERR_FIN_ONLY  = 4'd8,
    ERR_NO_FLAGS  = 4'd9,
    ERR_FIN_RST   = 4'd10,
    ERR_SYN_URG   = 4'd11,
    ERR_SYN_RST   = 4'd12,
    ERR_SYN_FIN   = 4'd13
  } l4_err_e;

  localparam logic [7:0] PROTO_TCP   = 8'd6;
  localparam logic [7:0] PROTO_UDP   = 8'd17;
  localparam int         TCP_MIN_HDR = 20;
  localparam int         UDP_MIN_HDR = 8;
  localparam logic [3:0] TCP_MIN_DOFF = 4'd5;

  // Byte offsets of the captured fields (fixed by the wire format)
  localparam int OFS_SPORT = 0;
  localparam int OFS_DPORT = 2;
  localparam int OFS_ULEN  = 4;
  localparam int OFS_UCSUM = 6;
  localparam int OFS_DOFF  = 12;
  localparam int OFS_FLAGS = 13;

  typedef struct packed {
    logic [15:0] sport;
    logic [15:0] dport;
    logic [15:0] udp_len;
    logic [15:0] udp_csum;
    logic [3:0]  doff;
    logic [7:0]  flags;
  } l4_hdr_t;

  // Illegal flag combinations, lowest code first
  function automatic l4_err_e flag_verdict(input logic [7:0] f);
    logic fin, syn, rst, urg;
    fin = f[0];
    syn = f[1];
    rst = f[2];
    urg = f[5];
    if (f[5:0] == 6'b000001)  return ERR_FIN_ONLY;
    else if (f[5:0] == 6'b0)  return ERR_NO_FLAGS;
    else if (fin && rst)      return ERR_FIN_RST;
    else if (syn && urg)      return ERR_SYN_URG;
    else if (syn && rst)      return ERR_SYN_RST;
    else if (syn && fin)      return ERR_SYN_FIN;
    else                      return ERR_NONE;
  endfunction

endpackage

// File: rtl/l4cls_hdr_capture.sv
module l4cls_hdr_capture
  import l4cls_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_ok,
  input  logic             beat_sop,
  input  logic [7:0]       beat_data,
  input  logic [7:0]       proto_in,
  input  logic [LEN_W-1:0] ip_len_in,
  output logic [LEN_W-1:0] beat_idx,
  output logic [LEN_W-1:0] byte_cnt,
  output l4_hdr_t          hdr,
  output logic [7:0]       proto,
  output logic [LEN_W-1:0] ip_len
);

  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic [LEN_W-1:0] cnt_q, cnt_d;
  l4_hdr_t          hdr_q, hdr_d;
  logic [7:0]       proto_q, proto_d;
  logic [LEN_W-1:0] iplen_q, iplen_d;

  assign beat_idx = beat_sop ? '0 : cnt_q;

  always_comb begin
    cnt_d   = cnt_q;
    hdr_d   = hdr_q;
    proto_d = proto_q;
    iplen_d = iplen_q;
    if (beat_ok) begin
      cnt_d = (beat_idx == CNT_MAX) ? CNT_MAX : beat_idx + 1'b1;
      if (beat_sop) begin
        hdr_d   = '0;
        proto_d = proto_in;
        iplen_d = ip_len_in;
      end
      case (beat_idx)
        LEN_W'(OFS_SPORT):     hdr_d.sport[15:8]    = beat_data;
        LEN_W'(OFS_SPORT + 1): hdr_d.sport[7:0]     = beat_data;
        LEN_W'(OFS_DPORT):     hdr_d.dport[15:8]    = beat_data;
        LEN_W'(OFS_DPORT + 1): hdr_d.dport[7:0]     = beat_data;
        LEN_W'(OFS_ULEN):      hdr_d.udp_len[15:8]  = beat_data;
        LEN_W'(OFS_ULEN + 1):  hdr_d.udp_len[7:0]   = beat_data;
        LEN_W'(OFS_UCSUM):     hdr_d.udp_csum[15:8] = beat_data;
        LEN_W'(OFS_UCSUM + 1): hdr_d.udp_csum[7:0]  = beat_data;
        LEN_W'(OFS_DOFF):      hdr_d.doff           = beat_data[7:4];
        LEN_W'(OFS_FLAGS):     hdr_d.flags          = beat_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      hdr_q   <= '0;
      proto_q <= '0;
      iplen_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      hdr_q   <= hdr_d;
      proto_q <= proto_d;
      iplen_q <= iplen_d;
    end
  end

  assign byte_cnt = cnt_q;
  assign hdr      = hdr_q;
  assign proto    = proto_q;
  assign ip_len   = iplen_q;

  // Each accepted beat advances the count by one from its index
  assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && beat_idx != CNT_MAX) |=> (byte_cnt == $past(beat_idx) + 1'b1));

  // Idle beats leave every captured value untouched
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_ok |=> ($stable(byte_cnt) && $stable(hdr) && $stable(proto) && $stable(ip_len)));

  // Sideband taken only with the first byte
  assert_side_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && !beat_sop) |=> ($stable(proto) && $stable(ip_len)));

endmodule

// File: rtl/l4cls_csum_acc.sv
module l4cls_csum_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat_ok,
  input  logic        beat_sop,
  input  logic        low_lane,
  input  logic [7:0]  beat_data,
  input  logic [15:0] seed,
  output logic [15:0] acc
);

  logic [15:0] acc_q, acc_d;
  logic [15:0] base, addend;
  logic [16:0] raw;

  always_comb begin
    base   = beat_sop ? seed : acc_q;
    addend = low_lane ? {8'h00, beat_data} : {beat_data, 8'h00};
    raw    = {1'b0, base} + {1'b0, addend};
    acc_d  = acc_q;
    if (beat_ok) acc_d = raw[15:0] + {15'd0, raw[16]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_ok |=> $stable(acc));

  // With end-around carry a nonzero addend can never leave a zero sum
  assert_acc_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && beat_data != 8'h00) |=> (acc != 16'h0000));

endmodule

// File: rtl/l4cls_verdict.sv
module l4cls_verdict
  import l4cls_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_end,
  input  l4_hdr_t          hdr,
  input  logic [LEN_W-1:0] byte_cnt,
  input  logic [7:0]       proto,
  input  logic [LEN_W-1:0] ip_len,
  input  logic [15:0]      acc,
  output logic             verdict_valid,
  output logic [3:0]       verdict_code
);

  localparam logic [LEN_W-1:0] TCP_MIN = LEN_W'(TCP_MIN_HDR);
  localparam logic [LEN_W-1:0] UDP_MIN = LEN_W'(UDP_MIN_HDR);

  logic             valid_q, valid_d;
  logic             is_tcp, is_udp;
  logic [LEN_W-1:0] min_len, hdr_bytes;
  logic             malformed, len_bad, port_zero, csum_bad;
  l4_err_e          flag_code, cls;

  always_comb begin
    is_tcp    = (proto == PROTO_TCP);
    is_udp    = (proto == PROTO_UDP);
    min_len   = is_tcp ? TCP_MIN : UDP_MIN;
    hdr_bytes = LEN_W'({hdr.doff, 2'b00});
    malformed = (byte_cnt < min_len) ||
                (is_tcp && ((hdr.doff < TCP_MIN_DOFF) || (hdr_bytes > byte_cnt)));
    len_bad   = (byte_cnt != ip_len) || (is_udp && (LEN_W'(hdr.udp_len) != ip_len));
    port_zero = (hdr.sport == 16'd0) || (hdr.dport == 16'd0);
    flag_code = is_tcp ? flag_verdict(hdr.flags) : ERR_NONE;
    csum_bad  = (acc != 16'hFFFF) && !(is_udp && hdr.udp_csum == 16'd0);

    if (!(is_tcp || is_udp))      cls = ERR_NONE;
    else if (malformed)           cls = ERR_MALFORMED;
    else if (len_bad)             cls = ERR_LENGTH;
    else if (port_zero)           cls = ERR_PORT0;
    else if (flag_code != ERR_NONE) cls = flag_code;
    else if (csum_bad)            cls = ERR_CSUM;
    else                          cls = ERR_NONE;
  end

  assign valid_d = pkt_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign verdict_valid = valid_q;
  assign verdict_code  = valid_q ? cls : ERR_NONE;

  assert_done_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(pkt_end));

  assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> (verdict_code inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4,
                                            4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13}));

  assert_udp_nocsum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && proto == PROTO_UDP && hdr.udp_csum == 16'd0) |-> (verdict_code != 4'd2));

  assert_short_hdr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && (proto == PROTO_TCP || proto == PROTO_UDP) && byte_cnt < UDP_MIN)
      |-> (verdict_code == 4'd1));

  assert_other_proto_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && proto != PROTO_TCP && proto != PROTO_UDP) |-> (verdict_code == 4'd0));

endmodule

// File: rtl/l4_err_classifier.sv
module l4_err_classifier
  import l4cls_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       in_data,
  input  logic [7:0]       ip_proto,
  input  logic [LEN_W-1:0] ip_l4_len,
  input  logic [15:0]      ip_psum,
  output logic             verdict_valid,
  output logic [3:0]       verdict_code
);

  // Asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  logic [LEN_W-1:0] beat_idx, byte_cnt, ip_len;
  l4_hdr_t          hdr;
  logic [7:0]       proto;
  logic [15:0]      acc;

  l4cls_hdr_capture #(.LEN_W(LEN_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .beat_ok   (in_valid),
    .beat_sop  (in_sop),
    .beat_data (in_data),
    .proto_in  (ip_proto),
    .ip_len_in (ip_l4_len),
    .beat_idx  (beat_idx),
    .byte_cnt  (byte_cnt),
    .hdr       (hdr),
    .proto     (proto),
    .ip_len    (ip_len)
  );

  l4cls_csum_acc u_csum (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .beat_ok   (in_valid),
    .beat_sop  (in_sop),
    .low_lane  (beat_idx[0]),
    .beat_data (in_data),
    .seed      (ip_psum),
    .acc       (acc)
  );

  l4cls_verdict #(.LEN_W(LEN_W)) u_verdict (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .pkt_end       (in_valid && in_eop),
    .hdr           (hdr),
    .byte_cnt      (byte_cnt),
    .proto         (proto),
    .ip_len        (ip_len),
    .acc           (acc),
    .verdict_valid (verdict_valid),
    .verdict_code  (verdict_code)
  );

endmodule

// File: tb/tb_l4_err_classifier.sv
`timescale 1ns/1ps
module tb_l4_err_classifier;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop;
  logic [7:0]  in_data, ip_proto;
  logic [15:0] ip_l4_len, ip_psum;
  logic        verdict_valid;
  logic [3:0]  verdict_code;

  always #2.5 clk = ~clk;

  l4_err_classifier dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .ip_proto(ip_proto), .ip_l4_len(ip_l4_len), .ip_psum(ip_psum),
    .verdict_valid(verdict_valid), .verdict_code(verdict_code)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0]  pkt [64];
  int          plen;
  logic [7:0]  proto;
  logic [15:0] iplen, psum;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ones_sum();
    int unsigned s = psum;
    for (int i = 0; i < plen; i++)
      s += (i % 2 == 0) ? {pkt[i], 8'h00} : {8'h00, pkt[i]};
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return s[15:0];
  endfunction

  function automatic int exp_code();
    bit tcp = (proto == 8'd6);
    bit udp = (proto == 8'd17);
    int d;
    logic [5:0] f;
    if (!tcp && !udp) return 0;
    if (plen < (tcp ? 20 : 8)) return 1;
    if (tcp) begin
      d = pkt[12][7:4];
      if (d < 5 || d * 4 > plen) return 1;
    end
    if (plen != iplen) return 3;
    if (udp && {pkt[4], pkt[5]} != iplen) return 3;
    if ({pkt[0], pkt[1]} == 16'd0 || {pkt[2], pkt[3]} == 16'd0) return 4;
    if (tcp) begin
      f = pkt[13][5:0];
      if (f == 6'b000001) return 8;
      if (f == 6'b000000) return 9;
      if (f[0] && f[2]) return 10;
      if (f[1] && f[5]) return 11;
      if (f[1] && f[2]) return 12;
      if (f[1] && f[0]) return 13;
    end
    if (udp && pkt[6] == 8'h00 && pkt[7] == 8'h00) return 0;
    if (ones_sum() != 16'hFFFF) return 2;
    return 0;
  endfunction

  function automatic string req_of(input int c);
    case (c)
      0: return "R1";
      1: return "R2";
      2: return "R6";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  // want: 6, 17, 0 = random TCP/UDP, other = that protocol
  // mode: 0 clean, 1 bad checksum, 2 length, 3 port zero, 4 flags(sel),
  //       5 malformed(sel), 6 UDP with zero checksum field and corrupted data
  task automatic make_pkt(input int want, input int mode, input int sel);
    int co, doff;
    logic [15:0] s;
    logic [7:0] fl [6];
    fl[0] = 8'h01; fl[1] = 8'h00; fl[2] = 8'h05; fl[3] = 8'h22; fl[4] = 8'h06; fl[5] = 8'h03;
    if (want == 0) proto = ($urandom % 2) ? 8'd6 : 8'd17;
    else           proto = 8'(want);
    if (mode == 6) proto = 8'd17;
    for (int i = 0; i < 64; i++) pkt[i] = 8'($urandom);
    plen = (proto == 8'd6) ? 20 + $urandom % 41 : 8 + $urandom % 53;
    pkt[1] = pkt[1] | 8'h01;
    pkt[3] = pkt[3] | 8'h01;
    if (proto == 8'd6) begin
      doff = 5 + $urandom % ((plen / 4) - 4);
      if (doff > 15) doff = 15;
      pkt[12] = {4'(doff), pkt[12][3:0]};
      pkt[13] = 8'h10 | (8'($urandom) & 8'hC8);
    end
    iplen = 16'(plen);
    psum  = 16'($urandom);
    if (proto == 8'd17) begin pkt[4] = 8'(plen >> 8); pkt[5] = 8'(plen); end
    case (mode)
      2: begin
        if (proto == 8'd17 && sel == 1) pkt[5] = pkt[5] + 8'd1;
        else iplen = iplen + 16'(1 + $urandom % 3);
      end
      3: begin
        if (sel == 0) begin pkt[0] = 8'h00; pkt[1] = 8'h00; end
        else          begin pkt[2] = 8'h00; pkt[3] = 8'h00; end
      end
      4: if (proto == 8'd6)
           pkt[13] = (sel < 2) ? {2'($urandom), fl[sel][5:0]} : (fl[sel] | (8'($urandom) & 8'hD8));
      5: begin
        if (sel == 1 && proto == 8'd6) pkt[12] = {4'($urandom % 5), pkt[12][3:0]};
        else if (sel == 2 && proto == 8'd6) begin
          plen = 20 + $urandom % 37; iplen = 16'(plen);
          pkt[12] = {4'd15, pkt[12][3:0]};
        end else begin
          plen = 1 + $urandom % ((proto == 8'd6) ? 19 : 7); iplen = 16'(plen);
        end
      end
      default: ;
    endcase
    co = (proto == 8'd6) ? 16 : 6;
    if (co + 1 < plen) begin
      pkt[co] = 8'h00; pkt[co + 1] = 8'h00;
      s = ~ones_sum();
      pkt[co] = s[15:8]; pkt[co + 1] = s[7:0];
    end
    if (mode == 1) pkt[co] = pkt[co] ^ 8'h5A;
    if (mode == 6) begin pkt[6] = 8'h00; pkt[7] = 8'h00; pkt[plen - 1] = pkt[plen - 1] ^ 8'h3C; end
  endtask

  task automatic drive_idle(inout bit stray);
    in_valid = 1'b0; in_sop = 1'($urandom); in_eop = 1'($urandom);
    in_data = 8'($urandom); ip_proto = 8'($urandom);
    ip_l4_len = 16'($urandom); ip_psum = 16'($urandom);
    @(negedge clk);
    if (verdict_valid) stray = 1'b1;
  endtask

  task automatic send_pkt(input string ctx, input bit gaps);
    int exp = exp_code();
    bit stray = 1'b0;
    for (int i = 0; i < plen; i++) begin
      if (gaps && ($urandom % 4 == 0)) drive_idle(stray);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == plen - 1); in_data = pkt[i];
      if (i == 0) begin ip_proto = proto; ip_l4_len = iplen; ip_psum = psum; end
      else begin ip_proto = 8'($urandom); ip_l4_len = 16'($urandom); ip_psum = 16'($urandom); end
      @(negedge clk);
      if (i != plen - 1 && verdict_valid) stray = 1'b1;
    end
    check({ctx, " R9 done strobe"}, int'(verdict_valid), 1);
    check({ctx, " ", req_of(exp), " code"}, int'(verdict_code), exp);
    check({ctx, " R9 no stray strobe"}, int'(stray), 0);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit stray = 1'b0;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_data = '0; ip_proto = '0; ip_l4_len = '0; ip_psum = '0;
    repeat (3) @(negedge clk);
    check("R9 reset strobe", int'(verdict_valid), 0);
    check("R9 reset code", int'(verdict_code), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Clean packets (R1)
    make_pkt(6, 0, 0);  send_pkt("R1 clean tcp", 1'b0);
    make_pkt(17, 0, 0); send_pkt("R1 clean udp", 1'b0);
    make_pkt(50, 0, 0); send_pkt("R1 other proto", 1'b1);
    // Every flag pattern (R5)
    for (int k = 0; k < 6; k++) begin make_pkt(6, 4, k); send_pkt("R5 flags", 1'b0); end
    // Malformed corners (R2)
    make_pkt(6, 0, 0); plen = 1; iplen = 16'd1; send_pkt("R2 one byte", 1'b0);
    make_pkt(17, 5, 0); send_pkt("R2 short udp", 1'b0);
    make_pkt(6, 5, 1);  send_pkt("R2 small offset", 1'b0);
    make_pkt(6, 5, 2);  send_pkt("R2 offset past end", 1'b0);
    make_pkt(17, 0, 0); plen = 8; iplen = 16'd8; pkt[4] = 8'd0; pkt[5] = 8'd8;
    pkt[6] = 8'h00; pkt[7] = 8'h00; send_pkt("R2 udp exact minimum", 1'b0);
    // Length, port, checksum
    make_pkt(6, 2, 0);  send_pkt("R3 ip length", 1'b0);
    make_pkt(17, 2, 1); send_pkt("R3 udp field", 1'b0);
    make_pkt(17, 3, 0); send_pkt("R4 src port", 1'b0);
    make_pkt(6, 3, 1);  send_pkt("R4 dst port", 1'b0);
    make_pkt(6, 1, 0);  send_pkt("R6 bad sum tcp", 1'b1);
    make_pkt(17, 6, 0); send_pkt("R7 no checksum", 1'b0);
    // Priority (R8)
    make_pkt(6, 3, 0); pkt[13] = 8'h00; iplen = iplen + 16'd1; send_pkt("R8 len over port", 1'b0);
    make_pkt(6, 3, 1); pkt[13] = 8'h00; send_pkt("R8 port over flags", 1'b0);
    make_pkt(6, 0, 0); pkt[13] = 8'h07; send_pkt("R8 fin-rst over syn", 1'b0);
    make_pkt(6, 4, 5); pkt[16] = pkt[16] ^ 8'hFF; send_pkt("R8 flags over sum", 1'b0);

    // Random packets with gaps and noisy sideband (R10)
    for (int n = 0; n < 400; n++) begin
      make_pkt(($urandom % 10 == 0) ? 1 + $urandom % 5 : 0, $urandom % 7, $urandom % 6);
      send_pkt("R10 random", 1'($urandom % 2));
    end

    drive_idle(stray);
    drive_idle(stray);
    check("R9 quiet after last", int'(stray), 0);
    check("R9 code zero when idle", int'(verdict_code), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule